// File: doc/BRIEF.md
# I2C Command Tag Stream Generator

This block takes one I2C message descriptor and produces the byte stream that an I2C controller's command FIFO consumes: a start prefix, the address byte or bytes, and then for every chunk of up to 256 data bytes an opcode byte and a length byte. For writes, each chunk's payload bytes follow its two tags in the same stream. For reads, only tags are produced. The bytes are packed four to a 32-bit word, least significant byte first, and leave through a ready/valid port. Every port uses a ready/valid handshake. When a descriptor is accepted, the block reports how many tag bytes and blocks the message needs, and how many receive tag bytes to expect.

The sequencer is a state machine with these states: `S_IDLE` (waits for a descriptor), `S_START` (emits 0x81), `S_HS_MARK` (emits 0xFF), `S_HS_START` (emits 0x81 again), `S_ADDR_LO` (emits the low address byte), `S_ADDR_HI` (emits the upper address bits), `S_OPCODE` (emits the block opcode), `S_LENGTH` (emits the block length) and `S_PAYLOAD` (passes write data through). Its transitions are:
- START goes to HS_MARK when high speed is requested, and to ADDR_LO otherwise.
- HS_MARK goes to HS_START, and HS_START goes to ADDR_LO.
- ADDR_LO goes to ADDR_HI for a 10-bit address, and to OPCODE otherwise. ADDR_HI goes to OPCODE.
- OPCODE goes to LENGTH.
- LENGTH goes to PAYLOAD for a write. For a read it goes to OPCODE when more blocks remain, and to IDLE after the final block.
- PAYLOAD goes to OPCODE at the end of a non-final block, and to IDLE at the end of the final block.
- A descriptor with zero length keeps the machine in IDLE and raises an error pulse.

A separate packer gathers the bytes into output words. It stalls the sequencer while a finished word waits at the output.

Top module: `i2c_tag_streamer`

## Requirements
- R1: When a descriptor of length L is accepted, the following values appear on the count outputs in the next cycle and are held until the next accept. block_count is ceil(L/256). tag_count is 2*block_count + 2, plus 2 with high speed and plus 1 with a 10-bit address. rx_tag_count is 2*block_count for a read and 0 for a write.
- R2: Every message starts with byte 0x81. The next byte is the address byte {addr[6:0], read}, where read is 1 for a read.
- R3: With the high-speed flag set, the prefix is 0x81, 0xFF, 0x81, followed by the address byte.
- R4: With a 10-bit address, the byte {5'b0, addr[9:7]} follows the low address byte.
- R5: Each block emits an opcode byte and then a length byte. The write opcode is 0x82 and the read opcode is 0x85. Non-final blocks carry length 0, which means 256 bytes. The final block carries L mod 256, so 0 when L is a multiple of 256.
- R6: The final block's opcode becomes 0x83 (write) or 0x87 (read) only when the last-message flag is set.
- R7: For a write, each block's two tags are followed by exactly that block's payload bytes, taken in order from the payload port. A read takes no payload bytes.
- R8: Stream byte i of a message goes to bits [8*(i mod 4) +: 8] of word i/4. The last partial word is padded with zero bytes. Each message starts in a new word.
- R9: While word_valid is high and word_ready is low, word_data stays stable and word_valid stays high. No byte is lost or repeated under backpressure on either side.
- R10: A descriptor with zero length is accepted and then rejected: len_err pulses for one cycle, no word is emitted and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted (idle) |
| desc_addr | input | 10 | Target address (7-bit uses bits 6:0) |
| desc_ten_bit | input | 1 | 10-bit addressing |
| desc_read | input | 1 | 1 = read, 0 = write |
| desc_len | input | LEN_W | Message length in bytes |
| desc_hs | input | 1 | High-speed prefix requested |
| desc_last | input | 1 | Final message of the transfer |
| pay_valid | input | 1 | Write payload byte offered |
| pay_ready | output | 1 | Payload byte taken |
| pay_data | input | 8 | Write payload byte |
| word_valid | output | 1 | Output word available |
| word_ready | input | 1 | Output FIFO can take a word |
| word_data | output | 32 | Packed word, LSB byte first |
| tag_count | output | LEN_W-5 | Total tag bytes of the message |
| block_count | output | LEN_W-7 | Number of blocks |
| rx_tag_count | output | LEN_W-6 | Expected receive tag bytes |
| len_err | output | 1 | One-cycle pulse on a zero-length descriptor |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that a write message gets exactly as many payload bytes as its length and that the descriptor fields stay stable while desc_valid waits. The stimulus fills the payload queue with exactly L bytes before it offers each write descriptor. It drives every input on the falling edge and holds a descriptor until it is accepted. It throttles pay_valid and word_ready at random, so that both stall paths of R9 are exercised while the assertions hold.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_HS_MARK,
        S_HS_START,
        S_ADDR_LO,
        S_ADDR_HI,
        S_OPCODE,
        S_LENGTH,
        S_PAYLOAD
    } seq_state_e;

    localparam logic [7:0] TAG_START   = 8'h81;
    localparam logic [7:0] TAG_HS      = 8'hFF;
    localparam logic [7:0] TAG_WR      = 8'h82;
    localparam logic [7:0] TAG_WR_STOP = 8'h83;
    localparam logic [7:0] TAG_RD      = 8'h85;
    localparam logic [7:0] TAG_RD_STOP = 8'h87;

    localparam int BLOCK_BYTES = 256;

endpackage

// File: rtl/i2c_tag_seq.sv
module i2c_tag_seq
    import i2c_tag_pkg::*;
#(
    parameter int LEN_W = 16,
    localparam int BLK_W = LEN_W - 7,
    localparam int TAG_W = BLK_W + 2,
    localparam int RX_W  = BLK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [9:0]       desc_addr,
    input  logic             desc_ten_bit,
    input  logic             desc_read,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_hs,
    input  logic             desc_last,
    input  logic             pay_valid,
    output logic             pay_ready,
    input  logic [7:0]       pay_data,
    output logic             byte_valid,
    input  logic             byte_ready,
    output logic [7:0]       byte_data,
    output logic             byte_last,
    output logic             len_err,
    output logic [TAG_W-1:0] tag_count,
    output logic [BLK_W-1:0] block_count,
    output logic [RX_W-1:0]  rx_tag_count
);

    seq_state_e state_q, state_d;

    logic [9:0]       addr_q;
    logic             rd_q, ten_q, hs_q, last_q;
    logic [7:0]       rem_q;
    logic [BLK_W-1:0] blk_left_q;
    logic [8:0]       pay_cnt_q;

    logic [LEN_W:0]   len_ext;
    logic [BLK_W-1:0] blk_calc;
    logic [TAG_W-1:0] tag_calc;
    logic             final_blk;
    logic [8:0]       blk_len;
    logic             blk_end;
    logic             byte_fire;
    logic             desc_fire;

    assign len_ext   = {1'b0, desc_len} + (LEN_W+1)'(BLOCK_BYTES - 1);
    assign blk_calc  = len_ext[LEN_W:8];
    assign tag_calc  = {1'b0, blk_calc, 1'b0} + TAG_W'(2)
                     + (desc_hs ? TAG_W'(2) : TAG_W'(0))
                     + (desc_ten_bit ? TAG_W'(1) : TAG_W'(0));
    assign final_blk = (blk_left_q == BLK_W'(1));
    assign blk_len   = (final_blk && rem_q != 8'd0) ? {1'b0, rem_q} : 9'(BLOCK_BYTES);
    assign blk_end   = (pay_cnt_q == blk_len - 9'd1);
    assign byte_fire = byte_valid && byte_ready;
    assign desc_fire = desc_valid && desc_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        desc_ready = 1'b0;
        pay_ready  = 1'b0;
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        byte_last  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                desc_ready = 1'b1;
                if (desc_valid && desc_len != '0) state_d = S_START;
            end
            S_START: begin
                byte_valid = 1'b1;
                byte_data  = TAG_START;
                if (byte_fire) state_d = hs_q ? S_HS_MARK : S_ADDR_LO;
            end
            S_HS_MARK: begin
                byte_valid = 1'b1;
                byte_data  = TAG_HS;
                if (byte_fire) state_d = S_HS_START;
            end
            S_HS_START: begin
                byte_valid = 1'b1;
                byte_data  = TAG_START;
                if (byte_fire) state_d = S_ADDR_LO;
            end
            S_ADDR_LO: begin
                byte_valid = 1'b1;
                byte_data  = {addr_q[6:0], rd_q};
                if (byte_fire) state_d = ten_q ? S_ADDR_HI : S_OPCODE;
            end
            S_ADDR_HI: begin
                byte_valid = 1'b1;
                byte_data  = {5'b0, addr_q[9:7]};
                if (byte_fire) state_d = S_OPCODE;
            end
            S_OPCODE: begin
                byte_valid = 1'b1;
                if (rd_q) byte_data = (final_blk && last_q) ? TAG_RD_STOP : TAG_RD;
                else      byte_data = (final_blk && last_q) ? TAG_WR_STOP : TAG_WR;
                if (byte_fire) state_d = S_LENGTH;
            end
            S_LENGTH: begin
                byte_valid = 1'b1;
                byte_data  = final_blk ? rem_q : 8'h00;
                byte_last  = rd_q && final_blk;
                if (byte_fire) begin
                    if (!rd_q)          state_d = S_PAYLOAD;
                    else if (final_blk) state_d = S_IDLE;
                    else                state_d = S_OPCODE;
                end
            end
            S_PAYLOAD: begin
                byte_valid = pay_valid;
                pay_ready  = byte_ready;
                byte_data  = pay_data;
                byte_last  = final_blk && blk_end;
                if (byte_fire && blk_end) state_d = final_blk ? S_IDLE : S_OPCODE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // descriptor capture, block and payload counters, reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            rd_q         <= 1'b0;
            ten_q        <= 1'b0;
            hs_q         <= 1'b0;
            last_q       <= 1'b0;
            rem_q        <= '0;
            blk_left_q   <= '0;
            pay_cnt_q    <= '0;
            len_err      <= 1'b0;
            tag_count    <= '0;
            block_count  <= '0;
            rx_tag_count <= '0;
        end else begin
            len_err <= desc_fire && (desc_len == '0);
            if (desc_fire && desc_len != '0) begin
                addr_q       <= desc_addr;
                rd_q         <= desc_read;
                ten_q        <= desc_ten_bit;
                hs_q         <= desc_hs;
                last_q       <= desc_last;
                rem_q        <= desc_len[7:0];
                blk_left_q   <= blk_calc;
                pay_cnt_q    <= '0;
                tag_count    <= tag_calc;
                block_count  <= blk_calc;
                rx_tag_count <= desc_read ? {blk_calc, 1'b0} : '0;
            end
            if (state_q == S_LENGTH && byte_fire && rd_q && !final_blk)
                blk_left_q <= blk_left_q - BLK_W'(1);
            if (state_q == S_PAYLOAD && byte_fire) begin
                if (blk_end) begin
                    pay_cnt_q  <= '0;
                    blk_left_q <= blk_left_q - BLK_W'(1);
                end else begin
                    pay_cnt_q  <= pay_cnt_q + 9'd1;
                end
            end
        end
    end

    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && desc_len == '0) |=> (len_err && desc_ready));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !byte_valid);

    p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && byte_last) |=> desc_ready);

    p_read_no_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> !rd_q);

endmodule

// File: rtl/i2c_word_packer.sv
module i2c_word_packer #(
    parameter int WORD_BYTES = 4,
    localparam int WORD_W = WORD_BYTES * 8,
    localparam int IDX_W  = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data
);

    logic [IDX_W-1:0] idx_q;
    logic             byte_fire;

    assign byte_ready = !word_valid || word_ready;
    assign byte_fire  = byte_valid && byte_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            if (word_valid && word_ready) word_valid <= 1'b0;
            if (byte_fire) begin
                if (idx_q == '0) word_data <= {{(WORD_W-8){1'b0}}, byte_data};
                else             word_data[{idx_q, 3'b000} +: 8] <= byte_data;
                if (byte_last || idx_q == IDX_W'(WORD_BYTES - 1)) begin
                    word_valid <= 1'b1;
                    idx_q      <= '0;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    p_block_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |-> !byte_ready);

endmodule

// File: rtl/i2c_tag_streamer.sv
module i2c_tag_streamer #(
    parameter int LEN_W = 16,
    localparam int BLK_W = LEN_W - 7,
    localparam int TAG_W = BLK_W + 2,
    localparam int RX_W  = BLK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [9:0]       desc_addr,
    input  logic             desc_ten_bit,
    input  logic             desc_read,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_hs,
    input  logic             desc_last,
    input  logic             pay_valid,
    output logic             pay_ready,
    input  logic [7:0]       pay_data,
    output logic             word_valid,
    input  logic             word_ready,
    output logic [31:0]      word_data,
    output logic [TAG_W-1:0] tag_count,
    output logic [BLK_W-1:0] block_count,
    output logic [RX_W-1:0]  rx_tag_count,
    output logic             len_err
);

    logic       byte_valid, byte_ready, byte_last;
    logic [7:0] byte_data;

    i2c_tag_seq #(.LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_ready   (desc_ready),
        .desc_addr    (desc_addr),
        .desc_ten_bit (desc_ten_bit),
        .desc_read    (desc_read),
        .desc_len     (desc_len),
        .desc_hs      (desc_hs),
        .desc_last    (desc_last),
        .pay_valid    (pay_valid),
        .pay_ready    (pay_ready),
        .pay_data     (pay_data),
        .byte_valid   (byte_valid),
        .byte_ready   (byte_ready),
        .byte_data    (byte_data),
        .byte_last    (byte_last),
        .len_err      (len_err),
        .tag_count    (tag_count),
        .block_count  (block_count),
        .rx_tag_count (rx_tag_count)
    );

    i2c_word_packer #(.WORD_BYTES(4)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .word_data  (word_data)
    );

endmodule

// File: tb/i2c_tag_streamer_tb_top.sv
module i2c_tag_streamer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int BLK_W = LEN_W - 7;
    localparam int TAG_W = BLK_W + 2;
    localparam int RX_W  = BLK_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             desc_valid = 1'b0;
    logic             desc_ready;
    logic [9:0]       desc_addr = '0;
    logic             desc_ten_bit = 1'b0;
    logic             desc_read = 1'b0;
    logic [LEN_W-1:0] desc_len = '0;
    logic             desc_hs = 1'b0;
    logic             desc_last = 1'b0;
    logic             pay_valid;
    logic             pay_ready;
    logic [7:0]       pay_data;
    logic             word_valid;
    logic             word_ready;
    logic [31:0]      word_data;
    logic [TAG_W-1:0] tag_count;
    logic [BLK_W-1:0] block_count;
    logic [RX_W-1:0]  rx_tag_count;
    logic             len_err;

    int n_checks = 0;
    int n_fails  = 0;
    int ready_pct = 100;
    int stall_viol = 0;
    bit held_v = 1'b0;
    logic [31:0] held_d = '0;

    byte unsigned pay_q[$];
    logic [31:0]  got_q[$];
    logic [31:0]  exp_q[$];

    i2c_tag_streamer #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_ten_bit(desc_ten_bit),
        .desc_read(desc_read), .desc_len(desc_len),
        .desc_hs(desc_hs), .desc_last(desc_last),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .tag_count(tag_count), .block_count(block_count),
        .rx_tag_count(rx_tag_count), .len_err(len_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // payload source: drive at falling edge, decide acceptance before next rise
    initial begin
        pay_valid = 1'b0;
        pay_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (pay_q.size() > 0 && ($urandom % 4) != 0) begin
                pay_valid = 1'b1;
                pay_data  = pay_q[0];
            end else begin
                pay_valid = 1'b0;
            end
            #1;
            if (pay_valid && pay_ready) void'(pay_q.pop_front());
        end
    end

    // word sink with random backpressure and hold tracking
    initial begin
        word_ready = 1'b0;
        forever begin
            @(negedge clk);
            word_ready = (($urandom % 100) < ready_pct);
            #1;
            if (held_v && !(word_valid && word_data == held_d)) stall_viol++;
            if (word_valid && word_ready) got_q.push_back(word_data);
            held_v = word_valid && !word_ready;
            held_d = word_data;
        end
    end

    function automatic void build_exp(input logic [9:0] a, input bit ten, input bit rd,
                                      input int len, input bit hs, input bit last,
                                      input byte unsigned pl[$]);
        byte unsigned bq[$];
        int nb;
        nb = (len + 255) / 256;
        bq.push_back(8'h81);
        if (hs) begin bq.push_back(8'hFF); bq.push_back(8'h81); end
        bq.push_back({a[6:0], rd});
        if (ten) bq.push_back({5'b0, a[9:7]});
        for (int b = 0; b < nb; b++) begin
            bit fin;
            int cnt;
            fin = (b == nb - 1);
            if (rd) bq.push_back((fin && last) ? 8'h87 : 8'h85);
            else    bq.push_back((fin && last) ? 8'h83 : 8'h82);
            bq.push_back(fin ? 8'(len % 256) : 8'h00);
            cnt = (fin && (len % 256) != 0) ? (len % 256) : 256;
            if (!rd) for (int i = 0; i < cnt; i++) bq.push_back(pl[b*256 + i]);
        end
        exp_q.delete();
        for (int i = 0; i < bq.size(); i += 4) begin
            logic [31:0] w;
            w = '0;
            for (int k = 0; k < 4; k++)
                if (i + k < bq.size()) w[8*k +: 8] = bq[i+k];
            exp_q.push_back(w);
        end
    endfunction

    task automatic run_msg(input string req, input logic [9:0] a, input bit ten,
                           input bit rd, input int len, input bit hs, input bit last);
        byte unsigned pl[$];
        int nb, etag, t, bad;
        nb = (len + 255) / 256;
        etag = 2*nb + 2 + (hs ? 2 : 0) + (ten ? 1 : 0);
        if (!rd) for (int i = 0; i < len; i++) pl.push_back(8'($urandom));
        build_exp(a, ten, rd, len, hs, last, pl);
        got_q.delete();
        stall_viol = 0;
        pay_q = pl;
        @(negedge clk);
        desc_addr = a; desc_ten_bit = ten; desc_read = rd;
        desc_len = LEN_W'(len); desc_hs = hs; desc_last = last;
        desc_valid = 1'b1;
        #1;
        while (!desc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        desc_valid = 1'b0;
        check(block_count == BLK_W'(nb), "R1", "block_count", 64'(block_count), 64'(nb));
        check(tag_count == TAG_W'(etag), "R1", "tag_count", 64'(tag_count), 64'(etag));
        check(rx_tag_count == RX_W'(rd ? 2*nb : 0), "R1", "rx_tag_count",
              64'(rx_tag_count), 64'(rd ? 2*nb : 0));
        t = 0;
        while (got_q.size() < exp_q.size() && t < 20000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        bad = -1;
        for (int i = 0; i < exp_q.size(); i++)
            if (bad < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) bad = i;
        check(bad < 0 && got_q.size() == exp_q.size(), req, "word stream",
              (bad >= 0 && bad < got_q.size()) ? 64'(got_q[bad]) : 64'(got_q.size()),
              (bad >= 0) ? 64'(exp_q[bad]) : 64'(exp_q.size()));
        check(pay_q.size() == 0, "R7", "payload consumed", 64'(pay_q.size()), 64'(0));
        check(stall_viol == 0, "R9", "held word under backpressure", 64'(stall_viol), 64'(0));
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20150414));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R8 R10: idle after reset, nothing emitted
        check(desc_ready == 1'b1, "R10", "reset desc_ready", 64'(desc_ready), 64'(1));
        check(word_valid == 1'b0, "R8", "reset word_valid", 64'(word_valid), 64'(0));
        check(len_err == 1'b0, "R10", "reset len_err", 64'(len_err), 64'(0));

        ready_pct = 100;
        run_msg("R2 R7 R8", 10'h05A, 1'b0, 1'b0, 3, 1'b0, 1'b1);
        ready_pct = 50;
        run_msg("R3 R5 R2", 10'h031, 1'b0, 1'b1, 1, 1'b1, 1'b0);
        run_msg("R4 R5 R6 R7", 10'h2C7, 1'b1, 1'b0, 300, 1'b0, 1'b1);
        run_msg("R5 R6", 10'h011, 1'b0, 1'b1, 512, 1'b0, 1'b1);
        ready_pct = 30;
        run_msg("R5 R6 R9", 10'h07F, 1'b0, 1'b0, 256, 1'b0, 1'b0);
        run_msg("R3 R4 R8", 10'h3FF, 1'b1, 1'b0, 2, 1'b1, 1'b1);

        // R10: zero-length descriptor
        @(negedge clk);
        desc_len = '0; desc_read = 1'b0; desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        check(len_err == 1'b1, "R10", "len_err pulse", 64'(len_err), 64'(1));
        @(negedge clk);
        #1;
        check(len_err == 1'b0, "R10", "len_err single cycle", 64'(len_err), 64'(0));
        check(word_valid == 1'b0 && desc_ready == 1'b1, "R10", "no words, idle",
              64'({word_valid, desc_ready}), 64'(2'b01));

        // R1 R9: randomized messages
        for (int n = 0; n < 20; n++) begin
            ready_pct = 30 + ($urandom % 71);
            run_msg("R1 R5 R8 R9", 10'($urandom), 1'($urandom), 1'($urandom),
                    1 + ($urandom % 700), 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule